// File: doc/BRIEF.md
# Adaptive Body Bias Controller

This block is the digital half of an adaptive body-bias loop. A replica of the die's critical path is launched each cycle of the target clock. The replica's completion flag, `path_done`, is high when the path finished within the target period. The controller registers that flag and passes it through a second register, so that the body-bias level produced by the external converter can settle after each code change. A settle timer blocks any further decision until the result for the new code has reached the second register.

While the path misses the target, the controller raises `bias_code` step by step toward stronger forward bias. Each step speeds the path up. When the re-sampled decision reads 1 for `LOCK_N` evaluations in a row, the controller declares lock and freezes the code. The freeze lasts until reset or a new `start` pulse. A code found earlier can be loaded directly with `load_en`; this skips the search and locks at once. `cnt_mode` selects fine or coarse steps. The code saturates at its all-ones value, and `at_limit` flags a target that is still not met there. `code_upd` marks every cycle in which the code carries a new value, so the converter interface can latch it.

Top module: `abb_ctrl`

## Requirements
- R1: While `rst_n` is low, `bias_code` is 0 (zero bias), and `locked`, `at_limit` and `code_upd` are 0.
- R2: `path_done` is registered and then re-sampled by a second register. After any code change the controller waits 2 cycles before its next decision. As a result, steps are at least 3 cycles apart, and fine-mode search stops exactly at the first passing code, with no overshoot.
- R3: During a search, a decision of 0 raises `bias_code` by 1 when `cnt_mode`=0 and by 4 when `cnt_mode`=1.
- R4: During a search, with no `start` or `load_en`, `bias_code` never decreases.
- R5: After 4 consecutive decisions of 1, `locked` goes to 1. From then on, `bias_code` holds even if `path_done` falls, until `start` or reset.
- R6: The code saturates at 255. A failing decision at 255 sets `at_limit`, which stays 1 until `start` or reset.
- R7: `code_upd` is 1 in exactly those cycles in which `bias_code` differs from its value in the previous cycle.
- R8: `load_en` makes `bias_code` equal `load_code` after the next edge and sets `locked`. A step due in the same cycle is dropped.
- R9: `start` sets `bias_code` to 0 and clears `locked` and `at_limit` at the next edge, then restarts the search. When `start` and `load_en` arrive in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock whose period is the timing goal |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_done | input | 1 | Replica path finished within the period (1 = met) |
| cnt_mode | input | 1 | Step size: 0 = +1, 1 = +4 |
| start | input | 1 | One-cycle pulse: clear the code and restart the search |
| load_en | input | 1 | Load `load_code` and lock |
| load_code | input | 8 | Preprogrammed bias code |
| bias_code | output | 8 | Body-bias code sent to the converter (higher = more forward bias) |
| code_upd | output | 1 | High in each cycle that shows a new code |
| locked | output | 1 | Search finished; code frozen |
| at_limit | output | 1 | Target still missed at the maximum code |

## Verification
A direct load can collide with a search step in the same cycle. The bench provokes this by counting edges after `start` while the path always fails: steps are due at the third and sixth edges, and `load_en` is raised for the sixth. The collision is judged correct if the code equals the loaded value rather than a stepped one, with a single strobe and lock set. `start` and `load_en` are also driven in the same cycle, and the result must be the cleared state with lock off.

// File: rtl/abb_pkg.sv
package abb_pkg;

    // Command applied to the bias code in one cycle, highest priority first
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_START = 2'd1,
        CMD_LOAD  = 2'd2,
        CMD_STEP  = 2'd3
    } bias_cmd_e;

    typedef enum logic {
        STEP_FINE   = 1'b0,
        STEP_COARSE = 1'b1
    } step_mode_e;

    function automatic int unsigned step_size(step_mode_e mode, int unsigned coarse);
        return (mode == STEP_COARSE) ? coarse : 1;
    endfunction

endpackage

// File: rtl/abb_phase_det.sv
module abb_phase_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic path_done,
    output logic decision
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] stage;
    } pd_t;

    pd_t pd_d, pd_q;

    // Stage 0 captures the replica result; later stages re-sample it
    always_comb begin
        pd_d = pd_q;
        pd_d.stage[0] = path_done;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            pd_d.stage[i] = pd_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign decision = pd_q.stage[SYNC_STAGES-1];
endmodule

// File: rtl/abb_settle_timer.sv
module abb_settle_timer #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    output logic ready
);
    localparam int TW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] hold;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rearm)                 tmr_d.hold = TW'(SETTLE_CYC);
        else if (tmr_q.hold != '0) tmr_d.hold = tmr_q.hold - 1'b1;
    end

    // Reset value lets the detector pipeline fill before the first decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{hold: TW'(SETTLE_CYC)};
        else        tmr_q <= tmr_d;
    end

    assign ready = (tmr_q.hold == '0);
endmodule

// File: rtl/abb_lock_det.sv
module abb_lock_det #(
    parameter int LOCK_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic force_lock,
    input  logic eval,
    input  logic decision,
    output logic locked
);
    localparam int CW = $clog2(LOCK_N + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          locked;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (clear) begin
            lk_d.run    = '0;
            lk_d.locked = 1'b0;
        end else if (force_lock) begin
            lk_d.run    = '0;
            lk_d.locked = 1'b1;
        end else if (eval) begin
            if (!decision) begin
                lk_d.run = '0;
            end else if (lk_q.run == CW'(LOCK_N - 1)) begin
                lk_d.run    = '0;
                lk_d.locked = 1'b1;
            end else begin
                lk_d.run = lk_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign locked = lk_q.locked;
endmodule

// File: rtl/abb_code_ctr.sv
module abb_code_ctr
    import abb_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int COARSE_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bias_cmd_e         cmd,
    input  step_mode_e        mode,
    input  logic [CODE_W-1:0] load_code,
    input  logic              limit_hit,
    output logic [CODE_W-1:0] code,
    output logic              upd,
    output logic              limit
);
    localparam int                SW    = CODE_W + 1;
    localparam logic [CODE_W-1:0] MAXC  = {CODE_W{1'b1}};
    localparam logic [SW-1:0]     MAXSW = {1'b0, MAXC};

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
        logic              limit;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum   = {1'b0, ctr_q.code} + SW'(step_size(mode, COARSE_STEP));
        ctr_d = ctr_q;
        unique case (cmd)
            CMD_START: begin
                ctr_d.code  = '0;
                ctr_d.limit = 1'b0;
            end
            CMD_LOAD:  ctr_d.code = load_code;
            CMD_STEP:  ctr_d.code = (sum > MAXSW) ? MAXC : sum[CODE_W-1:0];
            default:   ctr_d.code = ctr_q.code;
        endcase
        if (cmd != CMD_START && limit_hit) ctr_d.limit = 1'b1;
        ctr_d.upd = (ctr_d.code != ctr_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign code  = ctr_q.code;
    assign upd   = ctr_q.upd;
    assign limit = ctr_q.limit;
endmodule

// File: rtl/abb_ctrl.sv
module abb_ctrl
    import abb_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int COARSE_STEP = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 2,
    parameter int LOCK_N      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_done,
    input  logic              cnt_mode,
    input  logic              start,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] bias_code,
    output logic              code_upd,
    output logic              locked,
    output logic              at_limit
);
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

    logic      decision;
    logic      ready;
    logic      eval;
    logic      fail_slot;
    logic      limit_hit;
    bias_cmd_e cmd;

    abb_phase_det #(.SYNC_STAGES(SYNC_STAGES)) pd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .path_done (path_done),
        .decision  (decision)
    );

    abb_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rearm (cmd != CMD_IDLE),
        .ready (ready)
    );

    // A decision is taken only once the code has settled and no command overrides it
    always_comb begin
        eval      = ready && !locked && !start && !load_en;
        fail_slot = eval && !decision;
        limit_hit = fail_slot && (bias_code == MAXC);
        if (start)                               cmd = CMD_START;
        else if (load_en)                        cmd = CMD_LOAD;
        else if (fail_slot && bias_code != MAXC) cmd = CMD_STEP;
        else                                     cmd = CMD_IDLE;
    end

    abb_lock_det #(.LOCK_N(LOCK_N)) lock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .force_lock (load_en && !start),
        .eval       (eval),
        .decision   (decision),
        .locked     (locked)
    );

    abb_code_ctr #(.CODE_W(CODE_W), .COARSE_STEP(COARSE_STEP)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .mode      (step_mode_e'(cnt_mode)),
        .load_code (load_code),
        .limit_hit (limit_hit),
        .code      (bias_code),
        .upd       (code_upd),
        .limit     (at_limit)
    );
endmodule

// File: rtl/abb_ctrl_chk.sv
module abb_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              load_en,
    input logic [CODE_W-1:0] load_code,
    input logic [CODE_W-1:0] bias_code,
    input logic              code_upd,
    input logic              locked,
    input logic              at_limit
);
    localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

    a_r4_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !load_en) |=> (bias_code >= $past(bias_code)));

    a_r5_hold_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start && !load_en) |=> ($stable(bias_code) && locked));

    a_r6_limit_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit |-> (bias_code == MAXC));

    a_r7_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_code) |-> code_upd);

    a_r7_strobe_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> !$stable(bias_code));

    a_r8_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !start) |=> (bias_code == $past(load_code) && locked));

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bias_code == '0 && !locked && !at_limit));
endmodule

bind abb_ctrl abb_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_en   (load_en),
    .load_code (load_code),
    .bias_code (bias_code),
    .code_upd  (code_upd),
    .locked    (locked),
    .at_limit  (at_limit)
);

// File: tb/abb_ctrl_tb.sv
`timescale 1ns/1ps
module abb_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       path_done;
    logic       cnt_mode = 1'b0;
    logic       start = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_code = '0;
    logic [7:0] bias_code;
    logic       code_upd;
    logic       locked;
    logic       at_limit;
    int         thresh = 0;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;

    always #2.5 clk = ~clk;

    // Critical path replica: meets timing once the code reaches the threshold
    assign path_done = (int'(bias_code) >= thresh);

    abb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .path_done(path_done), .cnt_mode(cnt_mode),
        .start(start), .load_en(load_en), .load_code(load_code),
        .bias_code(bias_code), .code_upd(code_upd), .locked(locked), .at_limit(at_limit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam int NV = 8;
    localparam int V_TH[NV]   = '{0, 5, 5, 13, 40, 253, 256, 256};
    localparam int V_MODE[NV] = '{0, 0, 1, 1, 0, 1, 0, 1};
    localparam int V_CODE[NV] = '{0, 5, 8, 16, 40, 255, 255, 255};
    localparam int V_LOCK[NV] = '{1, 1, 1, 1, 1, 1, 0, 0};
    localparam int V_LIM[NV]  = '{0, 0, 0, 0, 0, 0, 1, 1};

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(bias_code == 0 && !locked && !at_limit && !code_upd, "R1 reset",
            {bias_code, 1'b0, locked, at_limit, code_upd}, 0);
        rst_n = 1'b1;

        // Table-driven searches: R2 R3 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            int prev;
            int bad;
            @(negedge clk);
            thresh   = V_TH[v];
            cnt_mode = V_MODE[v][0];
            start    = 1'b1;
            prev     = bias_code;
            bad      = 0;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 1000; c++) begin
                if (code_upd != (int'(bias_code) != prev)) bad++;
                prev = bias_code;
                @(negedge clk);
            end
            chk(int'(bias_code) == V_CODE[v], $sformatf("R2/R3 final code vec%0d", v),
                bias_code, V_CODE[v]);
            chk(int'(locked) == V_LOCK[v], $sformatf("R5 lock vec%0d", v), locked, V_LOCK[v]);
            chk(int'(at_limit) == V_LIM[v], $sformatf("R6 limit vec%0d", v), at_limit, V_LIM[v]);
            chk(bad == 0, $sformatf("R7 strobe mismatches vec%0d", v), bad, 0);
        end

        // Step spacing and load/step collision: R2 R3 R8 R9
        @(negedge clk);
        thresh = 256; cnt_mode = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(bias_code == 0 && !at_limit && !locked, "R9 start clears", {bias_code, at_limit}, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(bias_code == 0, "R2 no step inside settle window", bias_code, 0);
        @(posedge clk);
        @(negedge clk);
        chk(bias_code == 1 && code_upd, "R3 fine step", bias_code, 1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(bias_code == 1, "R2 step spacing", bias_code, 1);
        load_en = 1'b1; load_code = 8'd77;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
        chk(bias_code == 77 && code_upd && locked, "R8 load beats step",
            bias_code, 77);
        repeat (20) @(negedge clk);
        chk(bias_code == 77 && locked, "R5 loaded code frozen", bias_code, 77);

        // R9: start and load together
        start = 1'b1; load_en = 1'b1; load_code = 8'd99;
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        chk(bias_code == 0 && !locked, "R9 start beats load", {bias_code, locked}, 0);

        // R5: freeze after lock even when timing fails again
        thresh = 20;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        chk(bias_code == 20 && locked, "R5 locked at target", bias_code, 20);
        thresh = 100;
        repeat (50) @(negedge clk);
        chk(bias_code == 20 && locked, "R5 frozen after path fails", bias_code, 20);

        // R1: reset mid-search
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(bias_code == 0 && !locked && !at_limit && !code_upd, "R1 reset mid-run",
            bias_code, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule